// File: doc/BRIEF.md
# Memory Error Check and Reporting Controller

This block gathers error events from the on-chip memory checkers and turns them into sticky status flags, a non-maskable interrupt request and a reset request. One memory region is ECC protected and reports single-bit and double-bit error pulses. Three region groups are parity protected: the general group, the high-speed region and the retention region. Each of them reports a parity error pulse. A two-bit ECC policy decides whether single-bit and double-bit errors are recorded and whether they cause an action. Two separate select bits send ECC errors and parity errors to either the interrupt request or the reset request.

The controller also holds the read and write wait-cycle codes for the four region groups and drives them to the memory interfaces. Software reaches everything through a simple synchronous register port. A write takes effect at the clock edge where the write strobe is high. Read data is a combinational function of the address. The wait-cycle register and the check-control register are each guarded by their own key lock.

Top module: `sram_err_ctrl`

## Requirements
- R1: The ECC mode field sits in CHK (address 1) bits [1:0]. In mode 0, neither ECC pulse sets a status bit. In mode 1, single-bit pulses are ignored and double-bit pulses set status bit 1. In modes 2 and 3, both kinds are recorded.
- R2: An action is taken only on an acted error. Parity errors are always acted. A double-bit ECC error is acted in modes 1 to 3. A single-bit ECC error is acted only in mode 3; in mode 2 it is flagged but causes no action.
- R3: CHK bit 4 selects the action for ECC errors and CHK bit 5 selects the action for parity errors. A value of 0 selects the interrupt request and a value of 1 selects the reset request.
- R4: STATUS is at address 2 and its bits are: 0 ECC single-bit, 1 ECC double-bit, 2 general-group parity, 3 high-speed parity, 4 retention parity. The bits are sticky and are set in the cycle after the event. Writing 1 to a bit clears it and writing 0 leaves it alone. If a set and a clear fall in the same cycle, the set wins.
- R5: nmi_req is high while at least one set status bit is acted and has the interrupt action selected. It falls once those bits are cleared.
- R6: rst_req is a pulse that lasts exactly one cycle. It is high in the cycle after an acted error event whose action is reset.
- R7: A write of 0x3B to a key register (wait key at address 3, check key at address 4, data bits [7:0]) unlocks the matching register. A write of any other value locks it again. Writes to a locked register are ignored. Reading a key register returns 1 in bit 0 when that register is unlocked.
- R8: The wait-cycle lock and the check-control lock act independently of each other. STATUS clears are never locked.
- R9: A write to WAIT (address 0) takes a group mask in bits [3:0] (bit 0 general, 1 ECC, 2 high-speed, 3 retention), a read code in bits [6:4] and a write code in bits [10:8]. Every group selected by the mask takes both codes. A code n means n+1 wait cycles. Reading WAIT returns group g with its read code at bits [8g+2:8g] and its write code at bits [8g+6:8g+4]. The outputs rd_wait and wr_wait carry group g at bits [3g+2:3g].
- R10: After reset, the ECC mode is 0, both action selects are 0, every wait code is 0, STATUS is 0, both locks are engaged, and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ecc_sb_err | input | 1 | ECC region single-bit error pulse |
| ecc_db_err | input | 1 | ECC region double-bit error pulse |
| par_gen_err | input | 1 | General group parity error pulse |
| par_hs_err | input | 1 | High-speed region parity error pulse |
| par_ret_err | input | 1 | Retention region parity error pulse |
| nmi_req | output | 1 | Non-maskable interrupt request level |
| rst_req | output | 1 | One-cycle reset request pulse |
| rd_wait | output | 12 | Read wait codes, 3 bits per group |
| wr_wait | output | 12 | Write wait codes, 3 bits per group |

## Verification
Some rules are checked by the assertions on every cycle:
- status bits stay set until cleared;
- mode 0 never records a double-bit error, and modes below 2 never record a single-bit error;
- an interrupt request is never raised with empty status;
- a reset pulse always follows an error event;
- a locked register never changes;
- a wrong key always locks the register.

Only the bench's scenarios show the rest. These are the full mapping from mode and action selects to status, interrupt and reset outcomes, the exact one-cycle width of the reset pulse, the set-over-clear priority, the per-group mask of the wait fields with their readback layout, and the independence of the two locks.

// File: rtl/sec_pkg.sv
package sec_pkg;

    localparam int unsigned NGROUPS  = 4;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned NERR     = 5;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned DATA_W   = 32;
    localparam logic [7:0]  KEY_VAL  = 8'h3B;

    localparam logic [ADDR_W-1:0] A_WAIT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CHK   = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_WKEY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CKEY  = 3'd4;

    // error vector bit positions
    localparam int unsigned E_SB  = 0;
    localparam int unsigned E_DB  = 1;
    localparam int unsigned E_GEN = 2;
    localparam int unsigned E_HS  = 3;
    localparam int unsigned E_RET = 4;

    typedef enum logic [1:0] {
        ECC_OFF      = 2'd0,
        ECC_DB_ONLY  = 2'd1,
        ECC_SB_FLAG  = 2'd2,
        ECC_ALL      = 2'd3
    } ecc_mode_e;

    typedef struct packed {
        ecc_mode_e mode;
        logic      ecc_rst_sel;
        logic      par_rst_sel;
    } chk_cfg_t;

endpackage

// File: rtl/sec_key_lock.sv
module sec_key_lock
    import sec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       unlocked
);

    typedef struct packed {
        logic open;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key_wr) begin
            st_d.open = (key_data == KEY_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign unlocked = st_q.open;

    // R7: a write of any value other than the key leaves the lock engaged
    assert_bad_key_relocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_data != KEY_VAL) |=> !unlocked);

endmodule

// File: rtl/sec_wait_regs.sv
module sec_wait_regs
    import sec_pkg::*;
#(
    parameter int unsigned GROUPS = NGROUPS,
    parameter int unsigned CW     = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 unlocked,
    input  logic [GROUPS-1:0]    grp_mask,
    input  logic [CW-1:0]        rd_code,
    input  logic [CW-1:0]        wr_code,
    output logic [GROUPS*CW-1:0] rd_wait,
    output logic [GROUPS*CW-1:0] wr_wait
);

    typedef struct packed {
        logic [GROUPS-1:0][CW-1:0] rd;
        logic [GROUPS-1:0][CW-1:0] wr;
    } wait_st_t;

    wait_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < GROUPS; g++) begin
            if (wr_en && unlocked && grp_mask[g]) begin
                st_d.rd[g] = rd_code;
                st_d.wr[g] = wr_code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_out
        assign rd_wait[g*CW +: CW] = st_q.rd[g];
        assign wr_wait[g*CW +: CW] = st_q.wr[g];
    end

    // R7: nothing changes while the lock is engaged
    assert_locked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> ($stable(rd_wait) && $stable(wr_wait)));

endmodule

// File: rtl/sec_err_core.sv
module sec_err_core
    import sec_pkg::*;
#(
    parameter int unsigned N = NERR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  chk_cfg_t     cfg,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] status,
    output logic         nmi_req,
    output logic         rst_req
);

    typedef struct packed {
        logic [N-1:0] stat;
        logic         rst;
    } err_st_t;

    err_st_t st_d, st_q;

    logic [N-1:0] flag_en, act_en, rst_sel, qual_ev;

    always_comb begin
        flag_en        = '1;
        act_en         = '1;
        flag_en[E_SB]  = (cfg.mode == ECC_SB_FLAG) || (cfg.mode == ECC_ALL);
        flag_en[E_DB]  = (cfg.mode != ECC_OFF);
        act_en[E_SB]   = (cfg.mode == ECC_ALL);
        act_en[E_DB]   = (cfg.mode != ECC_OFF);
        rst_sel        = {N{cfg.par_rst_sel}};
        rst_sel[E_SB]  = cfg.ecc_rst_sel;
        rst_sel[E_DB]  = cfg.ecc_rst_sel;
        qual_ev        = ev & flag_en;
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = st_q.stat & ~(clr_we ? clr_mask : '0);
        st_d.stat = st_d.stat | qual_ev;
        st_d.rst  = |(qual_ev & act_en & rst_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status  = st_q.stat;
    assign rst_req = st_q.rst;
    assign nmi_req = |(st_q.stat & act_en & ~rst_sel);

    // R4: a status bit holds unless software clears it
    for (genvar i = 0; i < N; i++) begin : g_sticky
        assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(clr_we && clr_mask[i])) |=> status[i]);
    end

    // R1: mode 0 never records a double-bit error
    assert_mode_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == ECC_OFF && !status[E_DB]) |=> !status[E_DB]);

    // R1: modes 0 and 1 never record a single-bit error
    assert_sb_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.mode == ECC_OFF || cfg.mode == ECC_DB_ONLY) && !status[E_SB]) |=> !status[E_SB]);

    // R5: an interrupt request needs a pending status bit
    assert_nmi_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (|status));

    // R6: a reset pulse always follows an error event
    assert_rst_after_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(|ev));

endmodule

// File: rtl/sram_err_ctrl.sv
module sram_err_ctrl
    import sec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    input  logic                   ecc_sb_err,
    input  logic                   ecc_db_err,
    input  logic                   par_gen_err,
    input  logic                   par_hs_err,
    input  logic                   par_ret_err,
    output logic                   nmi_req,
    output logic                   rst_req,
    output logic [NGROUPS*CODE_W-1:0] rd_wait,
    output logic [NGROUPS*CODE_W-1:0] wr_wait
);

    localparam int unsigned LANE = 8;

    logic wait_open, chk_open;
    logic wr_wait_reg, wr_chk_reg, wr_stat_reg, wr_wkey, wr_ckey;
    logic [NERR-1:0] ev, status;

    assign wr_wait_reg = reg_wr && (reg_addr == A_WAIT);
    assign wr_chk_reg  = reg_wr && (reg_addr == A_CHK);
    assign wr_stat_reg = reg_wr && (reg_addr == A_STAT);
    assign wr_wkey     = reg_wr && (reg_addr == A_WKEY);
    assign wr_ckey     = reg_wr && (reg_addr == A_CKEY);

    assign ev = {par_ret_err, par_hs_err, par_gen_err, ecc_db_err, ecc_sb_err};

    sec_key_lock u_wait_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_wkey),
        .key_data (reg_wdata[7:0]),
        .unlocked (wait_open)
    );

    sec_key_lock u_chk_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (wr_ckey),
        .key_data (reg_wdata[7:0]),
        .unlocked (chk_open)
    );

    sec_wait_regs #(.GROUPS(NGROUPS), .CW(CODE_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_wait_reg),
        .unlocked (wait_open),
        .grp_mask (reg_wdata[NGROUPS-1:0]),
        .rd_code  (reg_wdata[4 +: CODE_W]),
        .wr_code  (reg_wdata[8 +: CODE_W]),
        .rd_wait  (rd_wait),
        .wr_wait  (wr_wait)
    );

    chk_cfg_t chk_d, chk_q;

    always_comb begin
        chk_d = chk_q;
        if (wr_chk_reg && chk_open) begin
            chk_d.mode        = ecc_mode_e'(reg_wdata[1:0]);
            chk_d.ecc_rst_sel = reg_wdata[4];
            chk_d.par_rst_sel = reg_wdata[5];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chk_q <= '{mode: ECC_OFF, ecc_rst_sel: 1'b0, par_rst_sel: 1'b0};
        else        chk_q <= chk_d;
    end

    sec_err_core #(.N(NERR)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .cfg      (chk_q),
        .clr_we   (wr_stat_reg),
        .clr_mask (reg_wdata[NERR-1:0]),
        .status   (status),
        .nmi_req  (nmi_req),
        .rst_req  (rst_req)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_WAIT: begin
                for (int g = 0; g < NGROUPS; g++) begin
                    reg_rdata[g*LANE +: CODE_W]     = rd_wait[g*CODE_W +: CODE_W];
                    reg_rdata[g*LANE + 4 +: CODE_W] = wr_wait[g*CODE_W +: CODE_W];
                end
            end
            A_CHK: begin
                reg_rdata[1:0] = chk_q.mode;
                reg_rdata[4]   = chk_q.ecc_rst_sel;
                reg_rdata[5]   = chk_q.par_rst_sel;
            end
            A_STAT: reg_rdata[NERR-1:0] = status;
            A_WKEY: reg_rdata[0] = wait_open;
            A_CKEY: reg_rdata[0] = chk_open;
            default: reg_rdata = '0;
        endcase
    end

    // R8: the check-control setting never moves while its own lock is engaged
    assert_chk_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_open |=> $stable(chk_q));

endmodule

// File: tb/sram_err_ctrl_bench.sv
module sram_err_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  errs = '0;
    logic        nmi_req, rst_req;
    logic [11:0] rd_wait, wr_wait;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    sram_err_ctrl u_sram_err_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ecc_sb_err(errs[0]), .ecc_db_err(errs[1]), .par_gen_err(errs[2]),
        .par_hs_err(errs[3]), .par_ret_err(errs[4]),
        .nmi_req(nmi_req), .rst_req(rst_req), .rd_wait(rd_wait), .wr_wait(wr_wait)
    );

    // {mode[1:0], ecc_rst, par_rst, errs[4:0], exp_status[4:0], exp_nmi, exp_rst}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        16'b00_0_0_00011_00000_0_0,
        16'b01_0_0_00001_00000_0_0,
        16'b01_0_0_00010_00010_1_0,
        16'b10_0_0_00001_00001_0_0,
        16'b10_1_0_00011_00011_0_1,
        16'b11_0_0_00001_00001_1_0,
        16'b11_1_0_00001_00001_0_1,
        16'b00_0_0_00100_00100_1_0,
        16'b00_0_1_11000_11000_0_1,
        16'b01_0_1_00101_00100_0_1,
        16'b11_1_0_10010_10010_1_1,
        16'b10_1_0_01001_01001_1_0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk);
        errs = e;
        @(negedge clk);
        errs = '0;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            check("R10 reset register", r, 32'h0);
        end
        check("R10 reset requests", {30'd0, nmi_req, rst_req}, 32'h0);
        check("R10 reset wait outputs", {8'd0, rd_wait, wr_wait}, 32'h0);

        // R7: locked check-control write ignored
        wr(3'd1, 32'h33);
        rd(3'd1, r);
        check("R7 locked CHK write ignored", r, 32'h0);

        // vector table: R1 R2 R3 R4 R5 R6
        wr(3'd4, 32'h3B);
        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            wr(3'd1, {26'd0, v[12], v[13], 2'b00, v[15:14]});
            wr(3'd2, 32'h1F);
            pulse(v[11:7]);
            rd(3'd2, r);
            check("R1 R2 status after event", r, {27'd0, v[6:2]});
            check("R3 R5 nmi level", {31'd0, nmi_req}, {31'd0, v[1]});
            check("R6 reset pulse", {31'd0, rst_req}, {31'd0, v[0]});
            @(negedge clk);
            check("R6 reset pulse ends", {31'd0, rst_req}, 32'h0);
            rd(3'd2, r);
            check("R4 status sticky", r, {27'd0, v[6:2]});
        end

        // R5: nmi falls when pending bits are cleared (last vector left hs set)
        wr(3'd2, 32'h08);
        check("R5 nmi drops after clear", {31'd0, nmi_req}, 32'h0);
        rd(3'd2, r);
        check("R4 partial clear keeps bit0", r, 32'h01);

        // R4: set wins over same-cycle clear
        wr(3'd1, 32'h03);
        wr(3'd2, 32'h1F);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h01; errs = 5'b00001;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; errs = '0;
        rd(3'd2, r);
        check("R4 set wins over clear", r, 32'h01);
        check("R5 nmi from acted single-bit", {31'd0, nmi_req}, 32'h1);

        // R9: wait-cycle writes per group mask
        wr(3'd3, 32'h3B);
        wr(3'd0, 32'h0000_0755);
        wr(3'd0, 32'h0000_0278);
        rd(3'd0, r);
        check("R9 wait readback", r, 32'h2775_0075);
        check("R9 rd_wait outputs", {20'd0, rd_wait}, {20'd0, 3'd7, 3'd5, 3'd0, 3'd5});
        check("R9 wr_wait outputs", {20'd0, wr_wait}, {20'd0, 3'd2, 3'd7, 3'd0, 3'd7});

        // R7: wrong key relocks; write then ignored
        wr(3'd3, 32'h12);
        rd(3'd3, r);
        check("R7 wrong key relocks", r, 32'h0);
        wr(3'd0, 32'h0000_011F);
        rd(3'd0, r);
        check("R7 locked WAIT write ignored", r, 32'h2775_0075);

        // R8: check lock still open while wait lock is engaged
        rd(3'd4, r);
        check("R8 check lock independent", r, 32'h1);
        wr(3'd1, 32'h31);
        rd(3'd1, r);
        check("R8 CHK writable while WAIT locked", r, 32'h31);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule